// File: doc/BRIEF.md
# Single-Cycle Converter Serial Output Sequencer

This block is the digital side of a converter that produces one result per cycle. After a power-on reset it starts converting at once. When the conversion completes, it loads the result into a holding register and goes to sleep. It then waits there until the host pulls chip select low and holds the serial clock low. Only then does it start shifting the result out, most significant bit first. The conversion itself is modelled as a timer that runs for a fixed number of system clocks. When the timer finishes, the block captures a result word from an input port.

The host frames each read with an active-low chip select and supplies its own serial clock. Both pins are synchronised into the system clock domain, and the block acts on their edges. A read ends either at the sixteenth falling clock edge or earlier, when chip select rises. Either way a new conversion starts, and no conversion can be stopped part way except by reset. Chip select also gates the output driver. Three indications report whether the block is in reset, converting, or sleeping in its low-power condition.

Top module: `adc_cycle_seq`

## Requirements
- R1: While `rst_n` is low, `por_o` is 1, `conv_o` is 0, `low_power_o` is 0 and the result register is cleared. After release, `por_o` stays 1 for exactly POR_CYCLES rising clock edges, and `conv_o` goes to 1 on the edge where `por_o` falls.
- R2: A conversion holds `conv_o` at 1 for exactly CONV_CYCLES rising clock edges, whatever happens on chip select and serial clock in that time. At its end, `result_i` is captured.
- R3: After a conversion the block sleeps (`conv_o` 0, no data shifted). It leaves sleep only when the synchronised chip select and serial clock are both low.
- R4: While sleeping, `low_power_o` is 1 when chip select is high and 0 when chip select is low.
- R5: `sdo_oe_o` is 1 exactly when the synchronised chip select is low. A value of 0 means the output is in high impedance.
- R6: With the output enabled, `sdo_o` reads 1 during a conversion (busy) and 0 while sleeping with a result ready.
- R7: On entry to the output phase, `sdo_o` shows bit 15 of the captured word. Each falling serial clock edge then advances one bit towards bit 0, so bit 15-i is valid while the clock is high before falling edge i+1.
- R8: The 16th falling serial clock edge of the output phase ends it and starts a new conversion.
- R9: A rising edge of chip select during the output phase ends it at once and starts a new conversion.
- R10: The captured word does not change while sleeping: serial clock activity with chip select high, and changes on `result_i`, leave the word later shifted out unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| cs_n_i | input | 1 | Host chip select, active low, asynchronous |
| sclk_i | input | 1 | Host serial clock, asynchronous |
| result_i | input | DATA_W | Converter result, captured when a conversion ends |
| sdo_o | output | 1 | Serial data / status value |
| sdo_oe_o | output | 1 | Output enable for the three-state serial data pin |
| por_o | output | 1 | Reset sequence in progress |
| conv_o | output | 1 | Conversion in progress |
| low_power_o | output | 1 | Sleeping with chip select high |

## Verification
The assertions check the sequencing rules on every clock. Reset always hands over to a conversion, and a conversion is never cut short. Sleep is left only when both pins are low, and the captured word stays frozen while the block sleeps. Both exits from the output phase, the 16th falling edge and a chip-select rise, lead straight back to converting. Some behaviour only the bench scenarios can show. These are the exact reset and conversion lengths, the bit order and values on the serial output, and the capture of the right word when `result_i` moves during sleep. Partial reads aborted after any bit count, and pin activity in the middle of a conversion, are covered there too.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_POR   = 2'd0,
        ST_CONV  = 2'd1,
        ST_SLEEP = 2'd2,
        ST_DATA  = 2'd3
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
    } seq_regs_t;

endpackage

// File: rtl/adc_pin_sync.sv
// Multi-stage synchroniser with one history stage per pin.
module adc_pin_sync #(
    parameter int unsigned         N_PINS  = 2,
    parameter int unsigned         STAGES  = 2,
    parameter logic [N_PINS-1:0]   RST_VAL = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pins_i,
    output logic [N_PINS-1:0] level_o,
    output logic [N_PINS-1:0] prev_o
);
    localparam int unsigned CHAIN = STAGES + 1;

    for (genvar g = 0; g < N_PINS; g++) begin : g_pin
        logic [CHAIN-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[CHAIN-2:0], pins_i[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {CHAIN{RST_VAL[g]}};
            else        chain_q <= chain_d;
        end

        assign level_o[g] = chain_q[STAGES-1];
        assign prev_o[g]  = chain_q[STAGES];
    end
endmodule

// File: rtl/adc_cycle_timer.sv
// Counts while run_i is high; done_o pulses on the last cycle of the window.
module adc_cycle_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             done_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign done_o = run_i && (cnt_q == limit_i - CNT_W'(1));

    always_comb begin
        if (!run_i || done_o) cnt_d = '0;
        else                  cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R2: a timing window never runs past its limit
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q < limit_i));
endmodule

// File: rtl/adc_out_shifter.sv
// Result holding register with MSB-first shifting and bit counter.
module adc_out_shifter #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              shift_i,
    output logic [DATA_W-1:0] word_o,
    output logic              msb_o,
    output logic              last_o
);
    localparam int unsigned BIT_W = $clog2(DATA_W + 1);

    logic [DATA_W-1:0] word_d, word_q;
    logic [BIT_W-1:0]  bit_d,  bit_q;

    always_comb begin
        word_d = word_q;
        bit_d  = bit_q;
        if (load_i) begin
            word_d = data_i;
            bit_d  = '0;
        end else if (shift_i) begin
            word_d = {word_q[DATA_W-2:0], 1'b0};
            bit_d  = bit_q + BIT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            bit_q  <= '0;
        end else begin
            word_q <= word_d;
            bit_q  <= bit_d;
        end
    end

    assign word_o = word_q;
    assign msb_o  = word_q[DATA_W-1];
    assign last_o = (bit_q == BIT_W'(DATA_W - 1));

    // R7: the bit position never leaves the word
    p_bit_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_q < BIT_W'(DATA_W));
endmodule

// File: rtl/adc_cycle_seq.sv
module adc_cycle_seq
    import adc_seq_pkg::*;
#(
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned CONV_CYCLES = 1660000,
    parameter int unsigned POR_CYCLES  = 50000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              sclk_i,
    input  logic [DATA_W-1:0] result_i,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output logic              por_o,
    output logic              conv_o,
    output logic              low_power_o
);
    localparam int unsigned LONGEST = (CONV_CYCLES > POR_CYCLES) ? CONV_CYCLES : POR_CYCLES;
    localparam int unsigned TMR_W   = $clog2(LONGEST + 1);
    localparam logic [TMR_W-1:0] CONV_LIM = TMR_W'(CONV_CYCLES);
    localparam logic [TMR_W-1:0] POR_LIM  = TMR_W'(POR_CYCLES);
    localparam int unsigned PIN_CS   = 1;
    localparam int unsigned PIN_SCLK = 0;

    seq_regs_t r_d, r_q;

    logic [1:0] pin_lvl, pin_prev;
    logic cs_s, sclk_s, cs_rise, sclk_fall;
    logic tmr_run, tmr_done;
    logic [TMR_W-1:0] tmr_limit;
    logic sh_load, sh_shift, sh_msb, sh_last;
    logic [DATA_W-1:0] sh_word;

    adc_pin_sync #(
        .N_PINS (2),
        .STAGES (SYNC_STAGES),
        .RST_VAL(2'b11)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i ({cs_n_i, sclk_i}),
        .level_o(pin_lvl),
        .prev_o (pin_prev)
    );

    assign cs_s      = pin_lvl[PIN_CS];
    assign sclk_s    = pin_lvl[PIN_SCLK];
    assign cs_rise   = pin_lvl[PIN_CS] & ~pin_prev[PIN_CS];
    assign sclk_fall = ~pin_lvl[PIN_SCLK] & pin_prev[PIN_SCLK];

    assign tmr_run   = (r_q.state == ST_POR) || (r_q.state == ST_CONV);
    assign tmr_limit = (r_q.state == ST_POR) ? POR_LIM : CONV_LIM;

    adc_cycle_timer #(
        .CNT_W(TMR_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (tmr_run),
        .limit_i(tmr_limit),
        .done_o (tmr_done)
    );

    adc_out_shifter #(
        .DATA_W(DATA_W)
    ) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (sh_load),
        .data_i (result_i),
        .shift_i(sh_shift),
        .word_o (sh_word),
        .msb_o  (sh_msb),
        .last_o (sh_last)
    );

    always_comb begin
        r_d      = r_q;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        unique case (r_q.state)
            ST_POR: begin
                if (tmr_done) r_d.state = ST_CONV;
            end
            ST_CONV: begin
                if (tmr_done) begin
                    sh_load   = 1'b1;
                    r_d.state = ST_SLEEP;
                end
            end
            ST_SLEEP: begin
                if (!cs_s && !sclk_s) r_d.state = ST_DATA;
            end
            ST_DATA: begin
                if (cs_rise) begin
                    r_d.state = ST_CONV;
                end else if (sclk_fall) begin
                    if (sh_last) r_d.state = ST_CONV;
                    else         sh_shift  = 1'b1;
                end
            end
            default: r_d.state = ST_POR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q.state <= ST_POR;
        else        r_q       <= r_d;
    end

    always_comb begin
        unique case (r_q.state)
            ST_DATA:  sdo_o = sh_msb;
            ST_SLEEP: sdo_o = 1'b0;
            default:  sdo_o = 1'b1;
        endcase
    end

    assign sdo_oe_o    = ~cs_s;
    assign por_o       = (r_q.state == ST_POR);
    assign conv_o      = (r_q.state == ST_CONV);
    assign low_power_o = (r_q.state == ST_SLEEP) && cs_s;

    // R1: the reset sequence always hands over to a conversion
    p_por_to_conv_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(por_o) |-> conv_o);

    // R2: a conversion continues until its timer expires
    p_conv_no_abort_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_CONV && !tmr_done) |=> (r_q.state == ST_CONV));

    // R3: sleep is kept while either pin is high
    p_sleep_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_SLEEP && (cs_s || sclk_s)) |=> (r_q.state == ST_SLEEP));

    // R4: the low-power indication implies the output is released
    p_lp_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
        low_power_o |-> !sdo_oe_o);

    // R8: final falling edge restarts conversion
    p_last_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_DATA && !cs_rise && sclk_fall && sh_last) |=> conv_o);

    // R9: chip-select rise aborts the read
    p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_DATA && cs_rise) |=> conv_o);

    // R10: captured word frozen across sleep
    p_word_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_SLEEP) |=> (r_q.state != ST_SLEEP || sh_word == $past(sh_word)));
endmodule

// File: tb/adc_cycle_seq_tb.sv
`timescale 1ns/100ps
module adc_cycle_seq_tb;
    localparam int DW   = 16;
    localparam int CONV = 60;
    localparam int POR  = 25;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b1;
    logic [DW-1:0] res = '0;
    logic sdo, sdo_oe, por, conv, lp;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    adc_cycle_seq #(
        .DATA_W     (DW),
        .CONV_CYCLES(CONV),
        .POR_CYCLES (POR),
        .SYNC_STAGES(2)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n_i     (cs_n),
        .sclk_i     (sclk),
        .result_i   (res),
        .sdo_o      (sdo),
        .sdo_oe_o   (sdo_oe),
        .por_o      (por),
        .conv_o     (conv),
        .low_power_o(lp)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_bit(input logic [DW-1:0] w, input int i);
        return w[DW-1-i];
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Waits for conv to rise, then counts rising edges until it falls.
    task automatic measure_conv(output int len, input bit toggle);
        int guard = 0;
        len = 0;
        while (conv !== 1'b1 && guard < 200) begin
            @(posedge clk); #1; guard++;
        end
        while (conv === 1'b1 && len < CONV + 50) begin
            @(posedge clk); #1; len++;
            if (toggle && len < CONV - 12) begin
                cs_n = 1'($urandom % 2);
                sclk = 1'($urandom % 2);
            end else if (toggle && len == CONV - 12) begin
                cs_n = 1'b1;
                sclk = 1'b1;
            end
            if (!toggle && cs_n == 1'b0 && len == CONV / 2) begin
                check("R6 busy", 32'(sdo), 32'd1);
                check("R5 enabled", 32'(sdo_oe), 32'd1);
            end
        end
    endtask

    // Reads n bits; bit i checked while clock is high; no wait after last fall.
    task automatic read_bits(input int n, input logic [DW-1:0] w, input string req);
        for (int i = 0; i < n; i++) begin
            sclk = 1'b1;
            idle(4);
            check(req, 32'(sdo), 32'(exp_bit(w, i)));
            sclk = 1'b0;
            if (i != n - 1) idle(4);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int n;
        int len;
        int k;
        logic [DW-1:0] w1, w2, exp_w;
        bit aborted;
        n = $urandom(32'd2024);

        // Reset state
        res = 16'hA53C;
        idle(5);
        check("R1 por in reset", 32'(por), 32'd1);
        check("R1 conv in reset", 32'(conv), 32'd0);
        check("R1 lp in reset", 32'(lp), 32'd0);
        check("R5 oe cs high", 32'(sdo_oe), 32'd0);

        // Reset length
        rst_n = 1'b1;
        n = 0;
        do begin
            @(posedge clk); #1; n++;
        end while (por === 1'b1 && n < POR + 20);
        check("R1 por length", 32'(n), 32'(POR));
        check("R1 conv after por", 32'(conv), 32'd1);

        // First conversion with cs low, clock high
        w1 = res;
        cs_n = 1'b0;
        measure_conv(len, 1'b0);
        check("R2 conv length", 32'(len), 32'(CONV));
        idle(5);
        check("R3 sleeping", 32'(conv), 32'd0);
        check("R4 normal power cs low", 32'(lp), 32'd0);
        check("R5 oe cs low", 32'(sdo_oe), 32'd1);
        check("R6 ready low", 32'(sdo), 32'd0);
        cs_n = 1'b1;
        idle(5);
        check("R4 low power cs high", 32'(lp), 32'd1);
        check("R5 high impedance", 32'(sdo_oe), 32'd0);

        // Clock activity and input changes in sleep
        w2 = 16'h5AC3;
        res = w2;
        for (int i = 0; i < 6; i++) begin
            sclk = ~sclk;
            idle(4);
        end
        sclk = 1'b1;
        idle(4);
        check("R3 still asleep", 32'(conv), 32'd0);
        check("R4 still low power", 32'(lp), 32'd1);
        cs_n = 1'b0;
        idle(20);
        check("R3 cs low clock high stays", 32'(conv), 32'd0);
        check("R4 restored power", 32'(lp), 32'd0);
        sclk = 1'b0;
        idle(4);
        check("R7 first bit D15", 32'(sdo), 32'(w1[DW-1]));
        read_bits(DW, w1, "R7 R10 shifted word");
        measure_conv(len, 1'b0);
        check("R8 restart after 16th edge", 32'(len), 32'(CONV));

        // cs and clock both low at end: enter output phase directly
        idle(4);
        check("R7 direct entry D15", 32'(sdo), 32'(w2[DW-1]));
        read_bits(5, w2, "R7 partial read");
        idle(4);
        check("R9 still reading", 32'(conv), 32'd0);
        cs_n = 1'b1;
        sclk = 1'b1;
        aborted = 1'b1;

        // Random iterations
        for (int it = 0; it < 14; it++) begin
            exp_w = 16'($urandom);
            res = exp_w;
            if (it == 0) begin
                measure_conv(len, 1'b0);
            end else begin
                measure_conv(len, 1'($urandom % 2));
            end
            if (aborted) check("R9 abort restarts conv", 32'(len), 32'(CONV));
            else         check("R8 full read restarts conv", 32'(len), 32'(CONV));
            check("R2 random conv length", 32'(len), 32'(CONV));
            cs_n = 1'b1;
            sclk = 1'b1;
            idle(5);
            check("R4 sleep low power", 32'(lp), 32'd1);
            k = int'($urandom % 5);
            for (int t = 0; t < 2 * k; t++) begin
                sclk = ~sclk;
                idle(3);
            end
            sclk = 1'b1;
            res = 16'($urandom);
            cs_n = 1'b0;
            idle(4);
            sclk = 1'b0;
            idle(4);
            check("R7 entry bit", 32'(sdo), 32'(exp_w[DW-1]));
            k = int'($urandom % 17);
            if (it == 1) k = 0;
            if (it == 2) k = 16;
            if (it == 3) k = 15;
            if (k == 16) begin
                read_bits(DW, exp_w, "R10 held word");
                aborted = 1'b0;
            end else begin
                if (k > 0) read_bits(k, exp_w, "R7 bits before abort");
                idle(4);
                check("R9 no early restart", 32'(conv), 32'd0);
                cs_n = 1'b1;
                sclk = 1'b1;
                aborted = 1'b1;
            end
        end
        measure_conv(len, 1'b0);
        check("R2 final conv", 32'(len), 32'(CONV));

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule